// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the destination address at the head of every incoming Ethernet frame, one byte per accepted beat, and decides whether the frame should be kept. It classifies the address as broadcast, group (multicast) or individual (unicast). It then applies the matching rule. An individual address must equal the programmed station address. A group address must hit a bit in a multicast hash table, and that bit is picked by a CRC-32 hash of the address. Broadcast needs its own enable. A promiscuous mode overrides all of the rules and accepts every frame.

The verdict appears one clock after the last address byte. It stays steady until the next frame begins, so the frame store downstream can sample it at any later point in the frame. The configuration bits, the station address and the hash table are plain inputs held by the surrounding register logic. Frame storage and CRC checking of the frame are left to other blocks.

Top module: `rxaf_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_group` are all 0.
- R2: When `cfg_promisc` is 1 at the cycle the last address byte is taken, the frame is accepted whatever its address.
- R3: An address whose six bytes are all 8'hFF is broadcast. Without promiscuous mode it is accepted exactly when `cfg_bcast_en` is 1.
- R4: An address that is not broadcast and has bit 0 of its first byte set is multicast. Without promiscuous mode it is accepted exactly when `cfg_mcast_en` is 1 and `hash_table[idx]` is 1. Table byte k occupies bits [8k+7:8k], so `idx[5:3]` picks the byte and `idx[2:0]` picks the bit within it.
- R5: The hash index `idx` is bits [31:26] of a 32-bit register. The register starts at all ones and takes each address byte least significant bit first. For each bit d, the register shifts left one place and is XORed with 32'h04C11DB7 when its old bit 31 XOR d is 1.
- R6: An address with bit 0 of its first byte clear is accepted, without promiscuous mode, only when every byte equals the station address. The first byte received is compared with `station_addr[7:0]` and byte i with `station_addr[8i+7:8i]`.
- R7: `dec_valid` rises on the clock edge that takes the sixth address byte and is therefore seen one cycle later. Cycles with `byte_vld` low do not advance the address. Bytes after the sixth leave `dec_valid`, `dec_accept` and `dec_group` unchanged.
- R8: `dec_group` equals bit 0 of the first address byte, so it is 1 for broadcast and multicast frames.
- R9: A beat with `sof` and `byte_vld` both high starts a new address with that byte as its first byte. It clears `dec_valid` on that edge, even if the previous address was incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Marks the current beat as the first byte of a frame |
| byte_vld | input | 1 | Frame byte valid this cycle |
| byte_data | input | 8 | Frame byte |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_en | input | 1 | Allow broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames that hit the hash table |
| station_addr | input | 48 | Own address, first byte in bits [7:0] |
| hash_table | input | 64 | Multicast hash bitmap, one bit per hash index |
| dec_valid | output | 1 | Verdict available and held |
| dec_accept | output | 1 | Frame is to be kept |
| dec_group | output | 1 | Destination is a group address |

## Verification
The bench builds the filter with its default parameters: six address bytes, a six-bit hash taken from the top of the CRC, and a 64-entry table. At these values every address class, every enable combination and the exact hash bit can be reached with a handful of directed frames. A multicast frame is checked first with only its computed table bit set, then with every bit except that one set. This shows that the hash picks exactly one entry. Gapped byte streams, trailing bytes and a frame cut short by a new start of frame exercise the timing and hold behaviour.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   typedef enum logic [1:0] {
      CLS_UNICAST = 2'd0,
      CLS_MULTI   = 2'd1,
      CLS_BCAST   = 2'd2
   } addr_class_e;

   typedef struct packed {
      logic valid;
      logic accept;
      logic group;
   } verdict_t;

endpackage

// File: rtl/rxaf_crc_step.sv
// One byte of a left-shifting CRC, data bits consumed LSB first.
module rxaf_crc_step #(
   parameter int                 CRC_W  = 32,
   parameter int                 DATA_W = 8,
   parameter logic [CRC_W-1:0]   POLY   = 32'h04C11DB7
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc_out
);

   always_comb begin
      logic [CRC_W-1:0] c;
      logic             fb;
      c = crc_in;
      for (int b = 0; b < DATA_W; b++) begin
         fb = c[CRC_W-1] ^ din[b];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      crc_out = c;
   end

endmodule

// File: rtl/rxaf_addr_track.sv
// Counts address bytes and accumulates hash, broadcast and station-match state.
module rxaf_addr_track #(
   parameter int               BYTE_W     = 8,
   parameter int               ADDR_BYTES = 6,
   parameter int               CRC_W      = 32,
   parameter logic [CRC_W-1:0] POLY       = 32'h04C11DB7,
   localparam int              ADDR_W     = BYTE_W * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [ADDR_W-1:0] station_addr,
   output logic              sof_take,
   output logic              take_last,
   output logic [CRC_W-1:0]  crc_fin,
   output logic              is_bcast,
   output logic              is_match,
   output logic              is_group
);

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CRC_W-1:0] crc_q;
   logic             bc_q, uc_q, grp_q;

   logic [CNT_W-1:0] pos;
   logic             take;
   logic [CRC_W-1:0] crc_base;
   logic             bc_base, uc_base;
   logic             byte_eq;

   assign sof_take  = byte_vld & sof;
   assign pos       = sof ? '0 : cnt_q;
   assign take      = byte_vld & (sof | (cnt_q < CNT_W'(ADDR_BYTES)));
   assign take_last = take & (pos == CNT_W'(ADDR_BYTES - 1));

   assign crc_base = sof ? '1   : crc_q;
   assign bc_base  = sof ? 1'b1 : bc_q;
   assign uc_base  = sof ? 1'b1 : uc_q;

   always_comb begin
      byte_eq = 1'b0;
      for (int g = 0; g < ADDR_BYTES; g++) begin
         if (pos == CNT_W'(g))
            byte_eq = (byte_data == station_addr[g*BYTE_W +: BYTE_W]);
      end
   end

   rxaf_crc_step #(
      .CRC_W  (CRC_W),
      .DATA_W (BYTE_W),
      .POLY   (POLY)
   ) u_crc (
      .crc_in  (crc_base),
      .din     (byte_data),
      .crc_out (crc_fin)
   );

   assign is_bcast = bc_base & (&byte_data);
   assign is_match = uc_base & byte_eq;
   assign is_group = sof ? byte_data[0] : grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(ADDR_BYTES);
         crc_q <= '1;
         bc_q  <= 1'b0;
         uc_q  <= 1'b0;
         grp_q <= 1'b0;
      end else if (take) begin
         cnt_q <= pos + 1'b1;
         crc_q <= crc_fin;
         bc_q  <= is_bcast;
         uc_q  <= is_match;
         grp_q <= is_group;
      end
   end

endmodule

// File: rtl/rxaf_verdict.sv
// Classifies the finished address and registers the held verdict.
module rxaf_verdict #(
   parameter int  CRC_W      = 32,
   parameter int  HASH_BITS  = 6,
   parameter bit  HASH_TOP   = 1'b1,
   localparam int TABLE_BITS = 1 << HASH_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sof_take,
   input  logic                  take_last,
   input  logic [CRC_W-1:0]      crc_fin,
   input  logic                  is_bcast,
   input  logic                  is_match,
   input  logic                  is_group,
   input  logic                  cfg_promisc,
   input  logic                  cfg_bcast_en,
   input  logic                  cfg_mcast_en,
   input  logic [TABLE_BITS-1:0] hash_table,
   output logic                  dec_valid,
   output logic                  dec_accept,
   output logic                  dec_group
);

   import rxaf_pkg::*;

   logic [HASH_BITS-1:0] hash_idx;
   addr_class_e          cls;
   logic                 keep;
   verdict_t             v_q;

   generate
      if (HASH_TOP) begin : g_hash_top
         assign hash_idx = crc_fin[CRC_W-1 -: HASH_BITS];
      end else begin : g_hash_low
         assign hash_idx = crc_fin[HASH_BITS-1:0];
      end
   endgenerate

   always_comb begin
      if (is_bcast)      cls = CLS_BCAST;
      else if (is_group) cls = CLS_MULTI;
      else               cls = CLS_UNICAST;
   end

   always_comb begin
      unique case (cls)
         CLS_BCAST: keep = cfg_bcast_en;
         CLS_MULTI: keep = cfg_mcast_en & hash_table[hash_idx];
         default:   keep = is_match;
      endcase
      if (cfg_promisc) keep = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else if (take_last) begin
         v_q.valid  <= 1'b1;
         v_q.accept <= keep;
         v_q.group  <= is_group;
      end else if (sof_take) begin
         v_q <= '0;
      end
   end

   assign dec_valid  = v_q.valid;
   assign dec_accept = v_q.accept;
   assign dec_group  = v_q.group;

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter #(
   parameter int                 BYTE_W     = 8,
   parameter int                 ADDR_BYTES = 6,
   parameter int                 CRC_W      = 32,
   parameter logic [CRC_W-1:0]   CRC_POLY   = 32'h04C11DB7,
   parameter int                 HASH_BITS  = 6,
   parameter bit                 HASH_TOP   = 1'b1,
   localparam int                ADDR_W     = BYTE_W * ADDR_BYTES,
   localparam int                TABLE_BITS = 1 << HASH_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sof,
   input  logic                  byte_vld,
   input  logic [BYTE_W-1:0]     byte_data,
   input  logic                  cfg_promisc,
   input  logic                  cfg_bcast_en,
   input  logic                  cfg_mcast_en,
   input  logic [ADDR_W-1:0]     station_addr,
   input  logic [TABLE_BITS-1:0] hash_table,
   output logic                  dec_valid,
   output logic                  dec_accept,
   output logic                  dec_group
);

   generate
      if (ADDR_BYTES < 1) begin : g_bad_bytes
         $error("rxaf_filter: ADDR_BYTES must be at least 1");
      end
      if (HASH_BITS < 1 || HASH_BITS > CRC_W || HASH_BITS > 12) begin : g_bad_hash
         $error("rxaf_filter: HASH_BITS out of range");
      end
      if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
         $error("rxaf_filter: CRC_POLY must have its constant term set");
      end
   endgenerate

   logic             sof_take, take_last;
   logic [CRC_W-1:0] crc_fin;
   logic             is_bcast, is_match, is_group;

   rxaf_addr_track #(
      .BYTE_W     (BYTE_W),
      .ADDR_BYTES (ADDR_BYTES),
      .CRC_W      (CRC_W),
      .POLY       (CRC_POLY)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof          (sof),
      .byte_vld     (byte_vld),
      .byte_data    (byte_data),
      .station_addr (station_addr),
      .sof_take     (sof_take),
      .take_last    (take_last),
      .crc_fin      (crc_fin),
      .is_bcast     (is_bcast),
      .is_match     (is_match),
      .is_group     (is_group)
   );

   rxaf_verdict #(
      .CRC_W     (CRC_W),
      .HASH_BITS (HASH_BITS),
      .HASH_TOP  (HASH_TOP)
   ) u_verdict (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof_take     (sof_take),
      .take_last    (take_last),
      .crc_fin      (crc_fin),
      .is_bcast     (is_bcast),
      .is_match     (is_match),
      .is_group     (is_group),
      .cfg_promisc  (cfg_promisc),
      .cfg_bcast_en (cfg_bcast_en),
      .cfg_mcast_en (cfg_mcast_en),
      .hash_table   (hash_table),
      .dec_valid    (dec_valid),
      .dec_accept   (dec_accept),
      .dec_group    (dec_group)
   );

endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk #(
   parameter int ADDR_BYTES = 6
) (
   input logic clk,
   input logic rst_n,
   input logic sof,
   input logic byte_vld,
   input logic cfg_promisc,
   input logic cfg_bcast_en,
   input logic cfg_mcast_en,
   input logic dec_valid,
   input logic dec_accept,
   input logic dec_group
);

   localparam int CW = $clog2(ADDR_BYTES + 2);

   logic [CW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen <= '0;
      else if (byte_vld && sof)
         seen <= CW'(1);
      else if (byte_vld && seen <= CW'(ADDR_BYTES) && seen != '0)
         seen <= seen + 1'b1;
   end

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && byte_vld && ADDR_BYTES > 1) |=> !dec_valid); // R9

   AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !(sof && byte_vld)) |=>
         (dec_valid && $stable(dec_accept) && $stable(dec_group))); // R7

   AST_VALID_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> (seen == CW'(ADDR_BYTES))); // R7

   AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_valid) && $past(cfg_promisc)) |-> dec_accept); // R2

   AST_GROUP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_valid) && !$past(cfg_promisc) && dec_group && dec_accept) |->
         ($past(cfg_bcast_en) || $past(cfg_mcast_en))); // R4

   AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_valid && !byte_vld) |=> !dec_valid); // R7

endmodule

bind rxaf_filter rxaf_filter_chk #(
   .ADDR_BYTES (ADDR_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sof          (sof),
   .byte_vld     (byte_vld),
   .cfg_promisc  (cfg_promisc),
   .cfg_bcast_en (cfg_bcast_en),
   .cfg_mcast_en (cfg_mcast_en),
   .dec_valid    (dec_valid),
   .dec_accept   (dec_accept),
   .dec_group    (dec_group)
);

// File: tb/rxaf_filter_tb.sv
module rxaf_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        cfg_promisc = 1'b0;
   logic        cfg_bcast_en = 1'b0;
   logic        cfg_mcast_en = 1'b0;
   logic [47:0] station_addr = '0;
   logic [63:0] hash_table = '0;
   logic        dec_valid, dec_accept, dec_group;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   localparam logic [47:0] STATION = {8'h56, 8'h34, 8'h12, 8'h00, 8'h54, 8'h52};
   localparam logic [47:0] MCAST   = {8'h01, 8'h00, 8'h00, 8'h5e, 8'h00, 8'h01};
   localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

   always #10 clk = ~clk;

   rxaf_filter dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof          (sof),
      .byte_vld     (byte_vld),
      .byte_data    (byte_data),
      .cfg_promisc  (cfg_promisc),
      .cfg_bcast_en (cfg_bcast_en),
      .cfg_mcast_en (cfg_mcast_en),
      .station_addr (station_addr),
      .hash_table   (hash_table),
      .dec_valid    (dec_valid),
      .dec_accept   (dec_accept),
      .dec_group    (dec_group)
   );

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         fb = c[31] ^ a[i];
         c  = c << 1;
         if (fb) c = c ^ 32'h04C11DB7;
      end
      return c[31:26];
   endfunction

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: valid/accept/group actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Sends n bytes of address a (first byte a[7:0]), gap idle cycles between bytes,
   // and returns at the negedge after the last byte was taken.
   task automatic send(input logic [47:0] a, input int n, input int gap, input bit start);
      for (int i = 0; i < n; i++) begin
         if (i > 0) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk); byte_vld = 1'b0; sof = 1'b0;
            end
         end
         @(negedge clk);
         sof       = start && (i == 0);
         byte_vld  = 1'b1;
         byte_data = a[8*i +: 8];
      end
      @(negedge clk);
      sof = 1'b0; byte_vld = 1'b0;
   endtask

   function automatic logic [2:0] outs();
      return {dec_valid, dec_accept, dec_group};
   endfunction

   task automatic t_reset();
      chk("R1 reset", outs(), 3'b000);
   endtask

   task automatic t_unicast();
      cfg_promisc = 0; cfg_bcast_en = 1; cfg_mcast_en = 1;
      send(STATION, 6, 0, 1);
      chk("R6 station match", outs(), 3'b110);
      send(STATION ^ 48'h0100_0000_0000, 6, 0, 1);
      chk("R6 last byte differs", outs(), 3'b100);
      send(STATION ^ 48'h0000_0000_0002, 6, 0, 1);
      chk("R6 first byte differs", outs(), 3'b100);
   endtask

   task automatic t_broadcast();
      cfg_bcast_en = 1; cfg_mcast_en = 0;
      send(BCAST, 6, 0, 1);
      chk("R3 R8 broadcast enabled", outs(), 3'b111);
      cfg_bcast_en = 0; cfg_mcast_en = 1; hash_table = '1;
      send(BCAST, 6, 0, 1);
      chk("R3 broadcast disabled", outs(), 3'b101);
      hash_table = '0;
   endtask

   task automatic t_multicast();
      logic [5:0] idx;
      idx = ref_idx(MCAST);
      cfg_bcast_en = 0; cfg_mcast_en = 1;
      hash_table = 64'd1 << idx;
      send(MCAST, 6, 0, 1);
      chk("R4 R5 hash bit set", outs(), 3'b111);
      hash_table = ~(64'd1 << idx);
      send(MCAST, 6, 0, 1);
      chk("R5 only own bit clear", outs(), 3'b101);
      hash_table = 64'd1 << idx; cfg_mcast_en = 0; cfg_bcast_en = 1;
      send(MCAST, 6, 0, 1);
      chk("R4 multicast disabled", outs(), 3'b101);
      hash_table = '0;
   endtask

   task automatic t_promisc();
      cfg_promisc = 1; cfg_bcast_en = 0; cfg_mcast_en = 0;
      send(48'h1122_3344_5566, 6, 0, 1);
      chk("R2 promiscuous unicast", outs(), 3'b110);
      send(MCAST, 6, 0, 1);
      chk("R2 promiscuous multicast", outs(), 3'b111);
      cfg_promisc = 0;
   endtask

   task automatic t_timing();
      cfg_bcast_en = 1; cfg_mcast_en = 0;
      send(BCAST, 5, 2, 1);
      chk("R7 five bytes no verdict", outs(), 3'b000);
      send(BCAST >> 40, 1, 0, 0);
      chk("R7 sixth byte after gaps", outs(), 3'b111);
      send(48'h0000_0000_0000, 4, 0, 0);
      chk("R7 trailing bytes ignored", outs(), 3'b111);
      send(STATION, 3, 0, 1);
      chk("R9 new start clears", outs(), 3'b000);
      send(STATION, 6, 1, 1);
      chk("R9 restart mid address", outs(), 3'b110);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      station_addr = STATION;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unicast();
      t_broadcast();
      t_multicast();
      t_promisc();
      t_timing();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule